// File: doc/BRIEF.md
# Microprogrammed Memory Self-Test Sequencer

This block tests a single-port synchronous RAM without outside help. A pulse on the start input launches a test program held in a small internal ROM. A program counter selects one microword at a time, and the control bits of that word decide what happens in that step. A step can reload the address counter, write a data pattern, or read a word and compare it against an expected value. A read can also write the complement back to the same word. A step can also loop back to the preceding step until the address counter reaches the end of its range. The program ends when a word with the stop bit is reached.

The stored program is a march test over a data background `BACKGROUND` (called D below). It fills the memory with D in ascending order. It then makes two ascending read-and-invert passes and two descending read-and-invert passes, and ends with a compare-only ascending pass. The engine reports completion on `done_o`. The verdict appears on `pass_o` and `fail_o`. Any mismatch latches `fail_o` at once, and the test still runs to its end.

Top module: `mbist_useq`

## Requirements
- R1: After reset `done_o`, `pass_o`, `fail_o`, `ram_we_o` and `ram_re_o` are all 0.
- R2: A microword has nine bits. From the most significant bit they are: loop, count-up, count-down, write-back, invert, compare, write, reload and stop. One full run of the stored program performs 5·N writes and 5·N reads, where N = 2^ADDR_W.
- R3: A loop step with count-up advances the program counter when the address is at its maximum. Otherwise it adds one to the address and returns to the previous step. A loop step with count-down does the same with limit 0, subtracting one. A reload step loads 0, or the maximum address if count-down is set. The address never wraps.
- R4: The invert bit selects ~D instead of D, both for write data and for the expected read value. The first pass writes D to addresses 0..N-1 in order. The second pass writes ~D in ascending order, and the fourth pass writes ~D in descending order.
- R5: A read step with write-back set writes the complement of its expected value to the same address in the following cycle. A read and a write are never issued in the same cycle.
- R6: A compared read whose data differs from the expected value sets `fail_o`. `fail_o` then stays set until the next accepted start, and the program still completes all of its steps.
- R7: `done_o` rises after the stop step once all outstanding compares have finished. `pass_o` equals the inverse of `fail_o` at that moment. Both stay until the next accepted start.
- R8: A start pulse while a test is running is ignored.
- R9: An accepted start clears `fail_o`, `done_o` and `pass_o` at the next clock edge and restarts the program at step 0.
- R10: After a complete run on fault-free memory every word holds D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| ram_addr_o | output | ADDR_W | RAM word address |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable; data is expected one cycle later |
| ram_rdata_i | input | DATA_W | RAM read data |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | Test finished without mismatch |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with ADDR_W = 4, DATA_W = 8 and BACKGROUND = 8'h55. With only 16 words, a complete run takes a few hundred cycles, so every write and read can be logged and checked for address order, polarity and write-back pairing. The alternating background puts opposite values on neighbouring bits. Because of this, a stuck bit in either polarity, at the first word, a middle word or the last word, is caught by some pass.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int PC_W      = 5;
  localparam int ROM_DEPTH = 1 << PC_W;

  // Field order from MSB: loop, up, down, write-back, invert, compare, write, reload, stop
  typedef struct packed {
    logic branch;
    logic inc;
    logic dec;
    logic xr;
    logic inv;
    logic cmp;
    logic wr;
    logic clr;
    logic tend;
  } uword_t;

  function automatic uword_t prog_word(input int idx);
    uword_t w;
    w = '0;
    case (idx)
      0:  w.clr = 1'b1;
      1:  w.wr = 1'b1;
      2:  begin w.branch = 1'b1; w.inc = 1'b1; end
      3:  w.clr = 1'b1;
      4:  begin w.cmp = 1'b1; w.xr = 1'b1; end
      5:  begin w.branch = 1'b1; w.inc = 1'b1; end
      6:  w.clr = 1'b1;
      7:  begin w.cmp = 1'b1; w.xr = 1'b1; w.inv = 1'b1; end
      8:  begin w.branch = 1'b1; w.inc = 1'b1; end
      9:  begin w.clr = 1'b1; w.dec = 1'b1; end
      10: begin w.cmp = 1'b1; w.xr = 1'b1; end
      11: begin w.branch = 1'b1; w.dec = 1'b1; end
      12: begin w.clr = 1'b1; w.dec = 1'b1; end
      13: begin w.cmp = 1'b1; w.xr = 1'b1; w.inv = 1'b1; end
      14: begin w.branch = 1'b1; w.dec = 1'b1; end
      15: w.clr = 1'b1;
      16: w.cmp = 1'b1;
      17: begin w.branch = 1'b1; w.inc = 1'b1; end
      default: w.tend = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mbist_rom.sv
module mbist_rom
  import mbist_pkg::*;
(
  input  logic [PC_W-1:0] pc_i,
  output uword_t          word_o
);

  uword_t rom_mem [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign rom_mem[i] = prog_word(i);
  end

  assign word_o = rom_mem[pc_i];

endmodule

// File: rtl/mbist_addr_ctr.sv
module mbist_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_top,
  input  logic              step,
  input  logic              step_down,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_top,
  output logic              at_bot
);

  localparam logic [ADDR_W-1:0] MAX = '1;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_top ? MAX : '0;
    end else if (step) begin
      if (step_down && addr_q != '0)
        addr_q <= addr_q - ONE;
      else if (!step_down && addr_q != MAX)
        addr_q <= addr_q + ONE;
    end
  end

  assign addr_o = addr_q;
  assign at_top = (addr_q == MAX);
  assign at_bot = (addr_q == '0);

  // R3: outside a reload the address moves by exactly one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && addr_q != $past(addr_q)) |->
      ((addr_q - $past(addr_q)) == ONE || ($past(addr_q) - addr_q) == ONE));

  // R3: counting up at the maximum holds the address
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !step_down && !load && addr_q == MAX) |=> (addr_q == MAX));

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              req,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              busy_o,
  output logic              fail_o
);

  logic              v0, v1, fail_q;
  logic [DATA_W-1:0] e0, e1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0; v1 <= 1'b0; e0 <= '0; e1 <= '0; fail_q <= 1'b0;
    end else begin
      v0 <= req && cmp_en;
      e0 <= exp_i;
      v1 <= v0;
      e1 <= e0;
      if (clear)
        fail_q <= 1'b0;
      else if (v1 && rdata_i != e1)
        fail_q <= 1'b1;
    end
  end

  assign busy_o = v0 || v1;
  assign fail_o = fail_q;

  // R6: a latched failure persists until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear) |=> fail_q);

  // R6: failure only rises when a compare was due
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(v1));

endmodule

// File: rtl/mbist_useq.sv
module mbist_useq
  import mbist_pkg::*;
#(
  parameter int                ADDR_W     = 10,
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] BACKGROUND = {(DATA_W/2){2'b01}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB, S_FIN} state_t;

  state_t            state;
  logic [PC_W-1:0]   pc_q;
  uword_t            uw;
  logic [ADDR_W-1:0] ctr_addr, addr_q;
  logic [DATA_W-1:0] wdata_q, wb_data, pat;
  logic              we_q, re_q, done_q, pass_q;
  logic              at_top, at_bot, run, lim, ctr_load, branch_back, rd_req;
  logic              cmp_busy, fail_w, clear;

  mbist_rom u_rom (.pc_i(pc_q), .word_o(uw));

  always_comb begin
    run         = (state == S_RUN) && !uw.tend;
    pat         = uw.inv ? ~BACKGROUND : BACKGROUND;
    lim         = uw.inc ? at_top : (uw.dec ? at_bot : 1'b1);
    ctr_load    = run && uw.clr;
    branch_back = run && !uw.clr && uw.branch && !lim;
    rd_req      = run && !uw.clr && !uw.branch && !uw.wr;
    clear       = (state == S_IDLE) && start_i;
  end

  mbist_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load), .load_top(uw.dec),
    .step(branch_back), .step_down(!uw.inc),
    .addr_o(ctr_addr), .at_top(at_top), .at_bot(at_bot)
  );

  mbist_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(clear), .req(rd_req), .cmp_en(uw.cmp),
    .exp_i(pat), .rdata_i(ram_rdata_i), .busy_o(cmp_busy), .fail_o(fail_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      pc_q    <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wb_data <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          state  <= S_RUN;
          pc_q   <= '0;
          done_q <= 1'b0;
          pass_q <= 1'b0;
        end
        S_RUN: begin
          if (uw.tend) begin
            state <= S_FIN;
          end else if (uw.clr || uw.branch) begin
            pc_q <= branch_back ? pc_q - 1'b1 : pc_q + 1'b1;
          end else if (uw.wr) begin
            we_q    <= 1'b1;
            addr_q  <= ctr_addr;
            wdata_q <= pat;
            pc_q    <= pc_q + 1'b1;
          end else begin
            re_q   <= 1'b1;
            addr_q <= ctr_addr;
            if (uw.xr) begin
              state   <= S_WB;
              wb_data <= ~pat;
            end else begin
              pc_q <= pc_q + 1'b1;
            end
          end
        end
        S_WB: begin
          we_q    <= 1'b1;
          wdata_q <= wb_data;
          pc_q    <= pc_q + 1'b1;
          state   <= S_RUN;
        end
        S_FIN: if (!cmp_busy) begin
          done_q <= 1'b1;
          pass_q <= !fail_w;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wdata_q;
  assign ram_we_o    = we_q;
  assign ram_re_o    = re_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_w;

  // R5: one RAM operation per cycle
  a_r5_one_op: assert property (@(posedge clk) disable iff (rst)
    !(ram_we_o && ram_re_o));

  // R7: verdicts never contradict
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && fail_o));

endmodule

// File: tb/sim_mbist_useq.sv
`timescale 1ns/1ps
module sim_mbist_useq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam logic [DW-1:0] BG = 8'h55;
  localparam int LOGN = 1024;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, rdata;
  logic ram_we, ram_re, done, pass, fail;

  always #4 clk = ~clk;

  mbist_useq #(.ADDR_W(AW), .DATA_W(DW), .BACKGROUND(BG)) u0 (
    .clk(clk), .rst(rst), .start_i(start),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_we_o(ram_we),
    .ram_re_o(ram_re), .ram_rdata_i(rdata),
    .done_o(done), .pass_o(pass), .fail_o(fail)
  );

  logic [DW-1:0] mem [N];
  logic          f_on = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_or = '0, f_and = '0;
  logic [AW-1:0] wr_a [LOGN];
  logic [DW-1:0] wr_d [LOGN];
  logic [AW-1:0] rd_a [LOGN];
  int wr_n = 0, rd_n = 0;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      if (wr_n < LOGN) begin wr_a[wr_n] <= ram_addr; wr_d[wr_n] <= ram_wdata; end
      wr_n <= wr_n + 1;
    end
    if (ram_re) begin
      if (f_on && ram_addr == f_addr) rdata <= (mem[ram_addr] | f_or) & ~f_and;
      else rdata <= mem[ram_addr];
      if (rd_n < LOGN) rd_a[rd_n] <= ram_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_once();
    int t;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    if (!done) check("R7 watchdog done", 0, 1);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    check("R1 fail", fail, 0);
    check("R1 we", ram_we, 0);
    check("R1 re", ram_re, 0);
  endtask

  task automatic t_clean();
    int wb, rb;
    bit ok_a, ok_d, ok_p, ok_m;
    f_on = 1'b0;
    wb = wr_n; rb = rd_n;
    run_once();
    check("R7 done", done, 1);
    check("R7 pass", pass, 1);
    check("R6 fail clean", fail, 0);
    check("R2 writes", wr_n - wb, 5 * N);
    check("R2 reads", rd_n - rb, 5 * N);
    ok_a = 1; ok_d = 1; ok_p = 1; ok_m = 1;
    for (int k = 0; k < N; k++) begin
      if (wr_a[wb + k] != k[AW-1:0]) ok_a = 0;
      if (rd_a[rb + 2*N + k] != AW'(N - 1 - k)) ok_a = 0;
      if (wr_a[wb + 3*N + k] != AW'(N - 1 - k)) ok_a = 0;
      if (wr_d[wb + k] != BG) ok_d = 0;
      if (wr_d[wb + N + k] != ~BG) ok_d = 0;
      if (wr_d[wb + 3*N + k] != ~BG) ok_d = 0;
      if (wr_a[wb + N + k] != rd_a[rb + k]) ok_p = 0;
      if (mem[k] != BG) ok_m = 0;
    end
    check("R3 address order", ok_a, 1);
    check("R4 write polarity", ok_d, 1);
    check("R5 write-back address", ok_p, 1);
    check("R10 final content", ok_m, 1);
    repeat (20) @(negedge clk);
    check("R7 done held", done, 1);
  endtask

  task automatic t_fault(input logic [AW-1:0] a, input logic [DW-1:0] o,
                         input logic [DW-1:0] z, input string tag);
    int rb;
    f_on = 1'b1; f_addr = a; f_or = o; f_and = z;
    rb = rd_n;
    run_once();
    check({"R6 fail ", tag}, fail, 1);
    check({"R7 pass low ", tag}, pass, 0);
    check({"R6 completes ", tag}, rd_n - rb, 5 * N);
    repeat (10) @(negedge clk);
    check({"R6 sticky ", tag}, fail, 1);
  endtask

  task automatic t_restart();
    int t;
    f_on = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 fail cleared", fail, 0);
    check("R9 done cleared", done, 0);
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    check("R9 pass after restart", pass, 1);
  endtask

  task automatic t_busy_start();
    int rb, t;
    f_on = 1'b0;
    rb = rd_n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    check("R8 reads unchanged", rd_n - rb, 5 * N);
    check("R8 pass", pass, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_fault(4'd5, 8'h01, 8'h00, "sa1 mid");
    t_restart();
    t_fault(4'd15, 8'h00, 8'h80, "sa0 top");
    t_fault(4'd0, 8'h02, 8'h00, "sa1 bottom");
    t_busy_start();
    t_clean();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule